// File: doc/BRIEF.md
# Event-Driven Serial Port

This block is a serial port that sits on a 32-bit memory-mapped register bus and follows a task/event programming model. Software writes to task registers to start or halt each direction. The hardware reports what happened by setting one-bit event registers: byte received, byte sent, framing error and receiver halted. An interrupt-enable mask selects which of these events drive the single level interrupt line. Software can also write any event register, most often to clear it with 0.

Received bytes go into a six-entry queue. Software drains the queue by reading the receive-data register. A write to the transmit-data register sends one byte. A second write made while a byte is still on the line waits in a one-byte holding register. The serial format is 8N1: one start bit, eight data bits with the least significant bit first, and one stop bit. Each bit lasts `DIV` clock cycles. Four pin-select words are kept as plain read/write storage.

Top module: `uev_uart`

## Requirements
- R1: After reset, every register reads 0, the receive queue is empty, the serial output is high and the interrupt output is low.
- R2: The interrupt-enable word is at 0x300. A write to 0x304 ORs the written value into it. A write to 0x308 clears every bit that is 1 in the written value. Reads of 0x300, 0x304 and 0x308 all return the current word.
- R3: The interrupt output is high exactly when at least one event is set and its enable bit is set. The pairs are: byte-received event (0x108) with bit 2, byte-sent event (0x11C) with bit 7, error event (0x124) with bit 9, and receiver-halted event (0x144) with bit 17.
- R4: Software may write an event register. A nonzero value sets the event to 1 and zero clears it. Reads return 0 or 1, and the interrupt output follows the new value.
- R5: When the transmitter runs, a write to 0x51C sends its low byte as one low start bit, eight data bits LSB first and one high stop bit, each `DIV` cycles long. When the stop bit ends, the byte-sent event is set.
- R6: A write to 0x51C made while a byte is on the line is held in one holding register. It is sent immediately after the current byte, so back-to-back writes leave the line in write order.
- R7: The receive input passes through a two-flop synchroniser. A falling edge starts a frame, and each bit is sampled at its middle. A frame with a high stop bit puts the byte in the queue and sets the byte-received event.
- R8: Reading 0x518 returns the byte at the head of the queue (in bits 7:0) and removes it, so bytes come out in arrival order.
- R9: The queue holds six bytes. A byte that completes while the queue is full is dropped. Reading 0x518 while the queue is empty returns the byte stored at the head position and changes nothing.
- R10: A stop bit sampled low discards the byte, sets the error event, and sets bit 2 (framing) of the error-source word at 0x480.
- R11: Writing 0x00C halts the transmitter. A byte already on the line still finishes, and later writes to 0x51C are ignored. Writing 0x004 stops the receiver after any frame in progress and then sets the receiver-halted event. Writing 0x000 or 0x008 starts the receiver or transmitter.
- R12: Neither direction works unless the word at 0x500 equals 4. With any other value, incoming frames are ignored and writes to 0x51C send nothing.
- R13: The four words at 0x508, 0x50C, 0x510 and 0x514 are plain storage and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| rxd_i | input | 1 | Serial receive input, idle high |
| txd_o | output | 1 | Serial transmit output, idle high |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps all 256 event/enable combinations on the interrupt line. A wrong enable bit position would raise the interrupt for the wrong event, or miss the right one. It sends every byte value in both directions, which catches reversed bit order and off-by-one bit counts. It also fills the queue past six entries and then reads it while empty. A design that overwrites the oldest entry, or that moves the head pointer on an empty read, returns the wrong bytes. Finally, it checks that a stop task lets the byte in flight finish while blocking later bytes, and that framing errors discard the byte instead of queueing it.

// File: rtl/uev_pkg.sv
package uev_pkg;
   localparam int OFS_W = 12;
   typedef logic [OFS_W-1:0] ofs_t;

   localparam ofs_t OFS_RX_GO      = 12'h000;
   localparam ofs_t OFS_RX_HALT    = 12'h004;
   localparam ofs_t OFS_TX_GO      = 12'h008;
   localparam ofs_t OFS_TX_HALT    = 12'h00C;
   localparam ofs_t OFS_EV_RXRDY   = 12'h108;
   localparam ofs_t OFS_EV_TXRDY   = 12'h11C;
   localparam ofs_t OFS_EV_ERR     = 12'h124;
   localparam ofs_t OFS_EV_RXTO    = 12'h144;
   localparam ofs_t OFS_IEN        = 12'h300;
   localparam ofs_t OFS_IEN_SET    = 12'h304;
   localparam ofs_t OFS_IEN_CLR    = 12'h308;
   localparam ofs_t OFS_ERRSRC     = 12'h480;
   localparam ofs_t OFS_ENABLE     = 12'h500;
   localparam ofs_t OFS_PIN0       = 12'h508;
   localparam ofs_t OFS_RXDATA     = 12'h518;
   localparam ofs_t OFS_TXDATA     = 12'h51C;

   localparam logic [31:0] EN_KEY = 32'd4;
   localparam int IB_RXRDY = 2;
   localparam int IB_TXRDY = 7;
   localparam int IB_ERR   = 9;
   localparam int IB_RXTO  = 17;
   localparam int ES_FRAME = 2;
   localparam int N_PIN    = 4;
endpackage

// File: rtl/uev_fifo.sv
module uev_fifo #(
   parameter int DEPTH = 6,
   parameter int W     = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uev_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] head, tail;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);
   assign dout    = mem[head];

   function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[tail] <= din;
            tail      <= adv(tail);
         end
         if (do_pop) head <= adv(head);
         if (do_push && !do_pop)      count <= count + CW'(1);
         else if (do_pop && !do_push) count <= count - CW'(1);
      end
   end
endmodule

// File: rtl/uev_rx.sv
module uev_rx #(
   parameter int DIV   = 16,
   localparam int CNTW = $clog2(DIV)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       rxd,
   output logic       valid,
   output logic       ferr,
   output logic [7:0] data,
   output logic       busy
);
   localparam logic [CNTW-1:0] HALF = CNTW'(DIV / 2 - 1);
   localparam logic [CNTW-1:0] FULL = CNTW'(DIV - 1);

   logic            s1, s2, s3;
   logic            active;
   logic [3:0]      idx;
   logic [CNTW-1:0] cnt;
   logic [7:0]      sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      end else begin
         s1 <= rxd; s2 <= s1; s3 <= s2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         cnt    <= '0;
         sh     <= '0;
         valid  <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         valid <= 1'b0;
         ferr  <= 1'b0;
         if (!active) begin
            if (run && s3 && !s2) begin
               active <= 1'b1;
               cnt    <= '0;
               idx    <= '0;
            end
         end else if (cnt == ((idx == 4'd0) ? HALF : FULL)) begin
            cnt <= '0;
            if (idx == 4'd0) begin
               if (s2) active <= 1'b0;
               else    idx    <= 4'd1;
            end else if (idx == 4'd9) begin
               active <= 1'b0;
               if (s2) valid <= 1'b1;
               else    ferr  <= 1'b1;
            end else begin
               sh  <= {s2, sh[7:1]};
               idx <= idx + 4'd1;
            end
         end else begin
            cnt <= cnt + CNTW'(1);
         end
      end
   end

   assign data = sh;
   assign busy = active;
endmodule

// File: rtl/uev_tx.sv
module uev_tx #(
   parameter int DIV   = 16,
   localparam int CNTW = $clog2(DIV)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       load,
   input  logic [7:0] ldata,
   output logic       line,
   output logic       done
);
   logic            busy, hold_v;
   logic [7:0]      hold_d;
   logic [9:0]      shreg;
   logic [3:0]      bitcnt;
   logic [CNTW-1:0] divcnt;
   logic            tick, fin, free, start;
   logic [7:0]      start_d;

   assign tick    = busy && (divcnt == CNTW'(DIV - 1));
   assign fin     = tick && (bitcnt == 4'd9);
   assign free    = !busy || fin;
   assign start   = run && free && (hold_v || load);
   assign start_d = hold_v ? hold_d : ldata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         hold_v <= 1'b0;
         hold_d <= '0;
         shreg  <= '1;
         bitcnt <= '0;
         divcnt <= '0;
         done   <= 1'b0;
      end else begin
         done <= fin;
         if (start) begin
            busy   <= 1'b1;
            shreg  <= {1'b1, start_d, 1'b0};
            bitcnt <= '0;
            divcnt <= '0;
            if (hold_v && load) hold_d <= ldata;
            else                hold_v <= 1'b0;
         end else begin
            if (run && load) begin
               hold_v <= 1'b1;
               hold_d <= ldata;
            end else if (!run) begin
               hold_v <= 1'b0;
            end
            if (fin) begin
               busy  <= 1'b0;
               shreg <= '1;
            end else if (tick) begin
               divcnt <= '0;
               bitcnt <= bitcnt + 4'd1;
               shreg  <= {1'b1, shreg[9:1]};
            end else if (busy) begin
               divcnt <= divcnt + CNTW'(1);
            end
         end
      end
   end

   assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uev_uart.sv
module uev_uart
   import uev_pkg::*;
#(
   parameter int DIV        = 16,
   parameter int FIFO_DEPTH = 6,
   parameter int AW         = 12,
   localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic          rxd_i,
   output logic          txd_o,
   output logic          irq_o
);
   generate
      if (AW < OFS_W) begin : g_bad_aw
         $error("uev_uart: AW too narrow for the register map");
      end
      if (DIV < 4) begin : g_bad_div
         $error("uev_uart: DIV must be at least 4");
      end
   endgenerate

   function automatic logic hit(input logic [AW-1:0] a, input ofs_t o);
      return a == AW'(o);
   endfunction

   logic          wr_s, rd_s, en_ok;
   logic [31:0]   ien_q, errsrc_q, enable_q;
   logic          ev_rxrdy_q, ev_txrdy_q, ev_err_q, ev_rxto_q;
   logic          rx_run_q, rx_pend_q, tx_run_q, rx_halt;
   logic          tx_done, rx_valid, rx_ferr, rx_busy;
   logic [7:0]    rx_data, fifo_dout;
   logic [CW-1:0] fifo_cnt;
   logic          fifo_push, fifo_pop;
   logic [N_PIN-1:0][31:0] pin_v;
   logic [31:0]   rdata_c;

   assign wr_s  = bus_sel & bus_wr;
   assign rd_s  = bus_sel & ~bus_wr;
   assign en_ok = (enable_q == EN_KEY);

   uev_tx #(.DIV(DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .run(tx_run_q & en_ok),
      .load(wr_s & hit(bus_addr, OFS_TXDATA)), .ldata(bus_wdata[7:0]),
      .line(txd_o), .done(tx_done));

   uev_rx #(.DIV(DIV)) u_rx (
      .clk(clk), .rst_n(rst_n), .run(rx_run_q & ~rx_pend_q & en_ok),
      .rxd(rxd_i), .valid(rx_valid), .ferr(rx_ferr), .data(rx_data),
      .busy(rx_busy));

   assign fifo_push = rx_valid & (fifo_cnt != CW'(FIFO_DEPTH));
   assign fifo_pop  = rd_s & hit(bus_addr, OFS_RXDATA);

   uev_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(rx_data),
      .pop(fifo_pop), .dout(fifo_dout), .count(fifo_cnt));

   assign rx_halt = rx_pend_q & ~rx_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0; errsrc_q <= '0; enable_q <= '0;
         ev_rxrdy_q <= 1'b0; ev_txrdy_q <= 1'b0;
         ev_err_q <= 1'b0; ev_rxto_q <= 1'b0;
         rx_run_q <= 1'b0; rx_pend_q <= 1'b0; tx_run_q <= 1'b0;
      end else begin
         if (wr_s && hit(bus_addr, OFS_RX_GO))   rx_run_q  <= 1'b1;
         if (wr_s && hit(bus_addr, OFS_RX_HALT)) rx_pend_q <= 1'b1;
         if (rx_halt) begin
            rx_run_q  <= 1'b0;
            rx_pend_q <= 1'b0;
         end
         if (wr_s && hit(bus_addr, OFS_TX_GO))   tx_run_q <= 1'b1;
         if (wr_s && hit(bus_addr, OFS_TX_HALT)) tx_run_q <= 1'b0;
         if (wr_s && hit(bus_addr, OFS_IEN))     ien_q <= bus_wdata;
         if (wr_s && hit(bus_addr, OFS_IEN_SET)) ien_q <= ien_q | bus_wdata;
         if (wr_s && hit(bus_addr, OFS_IEN_CLR)) ien_q <= ien_q & ~bus_wdata;
         if (wr_s && hit(bus_addr, OFS_ENABLE))  enable_q <= bus_wdata;
         if (wr_s && hit(bus_addr, OFS_ERRSRC))  errsrc_q <= bus_wdata;
         if (rx_ferr) errsrc_q[ES_FRAME] <= 1'b1;
         if (wr_s && hit(bus_addr, OFS_EV_RXRDY)) ev_rxrdy_q <= |bus_wdata;
         if (wr_s && hit(bus_addr, OFS_EV_TXRDY)) ev_txrdy_q <= |bus_wdata;
         if (wr_s && hit(bus_addr, OFS_EV_ERR))   ev_err_q   <= |bus_wdata;
         if (wr_s && hit(bus_addr, OFS_EV_RXTO))  ev_rxto_q  <= |bus_wdata;
         if (fifo_push) ev_rxrdy_q <= 1'b1;
         if (tx_done)   ev_txrdy_q <= 1'b1;
         if (rx_ferr)   ev_err_q   <= 1'b1;
         if (rx_halt)   ev_rxto_q  <= 1'b1;
      end
   end

   for (genvar g = 0; g < N_PIN; g++) begin : g_pin
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr_s && bus_addr == AW'(int'(OFS_PIN0) + 4 * g)) q <= bus_wdata;
      end
      assign pin_v[g] = q;
   end

   assign irq_o = (ev_rxrdy_q & ien_q[IB_RXRDY]) | (ev_txrdy_q & ien_q[IB_TXRDY])
                | (ev_err_q & ien_q[IB_ERR]) | (ev_rxto_q & ien_q[IB_RXTO]);

   always_comb begin
      rdata_c = '0;
      if (hit(bus_addr, OFS_IEN) || hit(bus_addr, OFS_IEN_SET) ||
          hit(bus_addr, OFS_IEN_CLR))            rdata_c = ien_q;
      else if (hit(bus_addr, OFS_EV_RXRDY))      rdata_c = {31'b0, ev_rxrdy_q};
      else if (hit(bus_addr, OFS_EV_TXRDY))      rdata_c = {31'b0, ev_txrdy_q};
      else if (hit(bus_addr, OFS_EV_ERR))        rdata_c = {31'b0, ev_err_q};
      else if (hit(bus_addr, OFS_EV_RXTO))       rdata_c = {31'b0, ev_rxto_q};
      else if (hit(bus_addr, OFS_ERRSRC))        rdata_c = errsrc_q;
      else if (hit(bus_addr, OFS_ENABLE))        rdata_c = enable_q;
      else if (hit(bus_addr, OFS_RXDATA))        rdata_c = {24'b0, fifo_dout};
      else begin
         for (int g = 0; g < N_PIN; g++)
            if (bus_addr == AW'(int'(OFS_PIN0) + 4 * g)) rdata_c = pin_v[g];
      end
   end

   assign bus_rdata = rdata_c;
endmodule

// File: rtl/uev_uart_chk.sv
module uev_uart_chk
   import uev_pkg::*;
#(
   parameter int FIFO_DEPTH = 6,
   parameter int AW         = 12,
   localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_s,
   input logic          rd_s,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   ien,
   input logic          ev_txrdy,
   input logic          ev_err,
   input logic [31:0]   errsrc,
   input logic          txd,
   input logic [CW-1:0] fifo_cnt,
   input logic          fifo_push
);
   // R2
   ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_s && bus_addr == AW'(OFS_IEN_SET) |=> (ien & $past(bus_wdata)) == $past(bus_wdata));

   // R2
   ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_s && bus_addr == AW'(OFS_IEN_CLR) |=> (ien & $past(bus_wdata)) == 32'd0);

   // R9
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(FIFO_DEPTH));

   // R8
   fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_s && bus_addr == AW'(OFS_RXDATA) && fifo_cnt != '0 && !fifo_push
      |=> fifo_cnt == $past(fifo_cnt) - CW'(1));

   // R5
   stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_txrdy) && !$past(wr_s && bus_addr == AW'(OFS_EV_TXRDY)) |-> $past(txd));

   // R10
   frame_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_err) && !$past(wr_s && bus_addr == AW'(OFS_EV_ERR)) |-> errsrc[ES_FRAME]);
endmodule

bind uev_uart uev_uart_chk #(.FIFO_DEPTH(FIFO_DEPTH), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .rd_s(rd_s), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .ien(ien_q), .ev_txrdy(ev_txrdy_q), .ev_err(ev_err_q),
   .errsrc(errsrc_q), .txd(txd_o), .fifo_cnt(fifo_cnt), .fifo_push(fifo_push));

// File: tb/sim_uev_uart.sv
module sim_uev_uart;
   localparam int DIV = 8;
   localparam int DEPTH = 6;
   localparam int AW = 12;

   logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, rxd = 1;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic txd, irq;
   int n_run = 0, n_fail = 0;
   bit finished = 0;

   logic [7:0] mm [DEPTH];
   int mh = 0, mt = 0, mc = 0;

   always #2 clk = ~clk;

   uev_uart #(.DIV(DIV), .FIFO_DEPTH(DEPTH), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rxd_i(rxd), .txd_o(txd), .irq_o(irq));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic rd_chk(string req, int a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic mpush(logic [7:0] b);
      if (mc < DEPTH) begin
         mm[mt] = b; mt = (mt + 1) % DEPTH; mc++;
      end
   endtask

   function automatic logic [7:0] mpeek();
      return mm[mh];
   endfunction

   task automatic mpop();
      if (mc > 0) begin
         mh = (mh + 1) % DEPTH; mc--;
      end
   endtask

   task automatic rx_chk(string req);
      logic [7:0] e;
      e = mpeek();
      mpop();
      rd_chk(req, 'h518, {24'b0, e});
   endtask

   task automatic rx_send(logic [7:0] b, logic stopb);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         rxd = (i == 0) ? 1'b0 : (i == 9) ? stopb : b[i-1];
         repeat (DIV - 1) @(negedge clk);
      end
      @(negedge clk);
      rxd = 1'b1;
      repeat (2 * DIV) @(negedge clk);
   endtask

   task automatic tx_grab(output logic [7:0] b, output bit ok);
      int w;
      w = 0; ok = 1; b = '0;
      while (txd !== 1'b0 && w < 40 * DIV) begin
         @(negedge clk); w++;
      end
      if (w >= 40 * DIV) begin
         ok = 0;
         return;
      end
      repeat (DIV / 2) @(negedge clk);
      if (txd !== 1'b0) ok = 0;
      for (int i = 0; i < 8; i++) begin
         repeat (DIV) @(negedge clk);
         b[i] = txd;
      end
      repeat (DIV) @(negedge clk);
      if (txd !== 1'b1) ok = 0;
   endtask

   task automatic quiet(output bit q);
      q = 1;
      for (int i = 0; i < 12 * DIV; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) q = 0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      bit ok, q;
      logic [31:0] ev;
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      chk("R1 txd", txd, 1);
      chk("R1 irq", irq, 0);
      rd_chk("R1 enable", 'h500, 0);
      rd_chk("R1 ien", 'h300, 0);
      rd_chk("R1 rxrdy", 'h108, 0);
      rd_chk("R1 errsrc", 'h480, 0);
      rd_chk("R1 rxdata", 'h518, 0);

      // R13 pin-select storage
      for (int g = 0; g < 4; g++) wr('h508 + 4 * g, 32'h1000_0001 * (g + 3));
      for (int g = 0; g < 4; g++) rd_chk("R13 pin", 'h508 + 4 * g, 32'h1000_0001 * (g + 3));

      // R2 enable aliases
      wr('h304, 32'h84);
      rd_chk("R2 ien", 'h300, 32'h84);
      rd_chk("R2 set alias", 'h304, 32'h84);
      wr('h308, 32'h04);
      rd_chk("R2 clr alias", 'h308, 32'h80);
      wr('h304, 32'h200);
      rd_chk("R2 or", 'h300, 32'h280);
      wr('h308, 32'hFFFF_FFFF);
      rd_chk("R2 clr all", 'h300, 0);

      // R4 software event writes
      wr('h144, 5);
      rd_chk("R4 set nonzero", 'h144, 1);
      wr('h144, 0);
      rd_chk("R4 clear", 'h144, 0);

      // R3 full sweep of event x enable patterns
      for (int m = 0; m < 16; m++) begin
         for (int e = 0; e < 16; e++) begin
            wr('h300, (32'(m & 1) << 2) | (32'((m >> 1) & 1) << 7) |
                      (32'((m >> 2) & 1) << 9) | (32'((m >> 3) & 1) << 17));
            wr('h108, e & 1);
            wr('h11C, (e >> 1) & 1);
            wr('h124, (e >> 2) & 1);
            wr('h144, (e >> 3) & 1);
            chk("R3 irq", irq, ((e & m) != 0));
         end
      end
      wr('h108, 0); wr('h11C, 0); wr('h124, 0); wr('h144, 0);
      chk("R4 irq after clear", irq, 0);
      wr('h300, 0);

      // R12 disabled: nothing moves
      wr('h500, 1);
      wr('h000, 1);
      wr('h008, 1);
      rx_send(8'h3C, 1'b1);
      rd_chk("R12 rx ignored", 'h108, 0);
      wr('h51C, 8'h55);
      quiet(q);
      chk("R12 tx ignored", q, 1);
      rd_chk("R12 no txrdy", 'h11C, 0);
      wr('h500, 4);

      // R5 all byte values on the line
      for (int v = 0; v < 256; v++) begin
         wr('h11C, 0);
         wr('h51C, v);
         tx_grab(b, ok);
         chk("R5 frame ok", ok, 1);
         chk("R5 byte", b, v[7:0]);
         repeat (DIV) @(negedge clk);
         rd_chk("R5 txrdy", 'h11C, 1);
      end
      wr('h304, 32'h80);
      chk("R3 irq txrdy", irq, 1);
      wr('h308, 32'h80);

      // R6 back-to-back writes keep order
      wr('h51C, 8'hA1);
      wr('h51C, 8'h4E);
      tx_grab(b, ok);
      chk("R6 first", {ok, b}, {1'b1, 8'hA1});
      tx_grab(b, ok);
      chk("R6 second", {ok, b}, {1'b1, 8'h4E});
      repeat (2 * DIV) @(negedge clk);

      // R7 every byte value received
      for (int v = 0; v < 256; v++) begin
         wr('h108, 0);
         rx_send(v[7:0], 1'b1);
         mpush(v[7:0]);
         rd_chk("R7 rxrdy", 'h108, 1);
         rx_chk("R7 rxdata");
      end

      // R8 arrival order
      rx_send(8'hC3, 1'b1); mpush(8'hC3);
      rx_send(8'h18, 1'b1); mpush(8'h18);
      rx_send(8'h7E, 1'b1); mpush(8'h7E);
      for (int i = 0; i < 3; i++) rx_chk("R8 order");

      // R9 overflow drops, empty read stale
      for (int k = 0; k < 8; k++) begin
         rx_send(8'h40 + 8'(k), 1'b1);
         mpush(8'h40 + 8'(k));
      end
      for (int i = 0; i < 6; i++) rx_chk("R9 depth");
      rx_chk("R9 empty read");
      rx_chk("R9 empty read again");

      // R10 framing error
      wr('h124, 0); wr('h480, 0); wr('h108, 0);
      rx_send(8'hE1, 1'b0);
      rd_chk("R10 err event", 'h124, 1);
      rd_chk("R10 errsrc", 'h480, 32'h4);
      rd_chk("R10 no rxrdy", 'h108, 0);
      rx_chk("R10 byte dropped");
      rx_send(8'h2B, 1'b1); mpush(8'h2B);
      rx_chk("R10 recovers");

      // R11 transmitter stop lets current byte finish
      wr('h11C, 0);
      wr('h51C, 8'h96);
      wr('h00C, 1);
      tx_grab(b, ok);
      chk("R11 in-flight byte", {ok, b}, {1'b1, 8'h96});
      repeat (DIV) @(negedge clk);
      rd_chk("R11 in-flight txrdy", 'h11C, 1);
      wr('h11C, 0);
      wr('h51C, 8'h3F);
      quiet(q);
      chk("R11 tx halted", q, 1);
      rd_chk("R11 no txrdy", 'h11C, 0);

      // R11 receiver stop
      wr('h144, 0);
      wr('h304, 32'h2_0000);
      wr('h004, 1);
      repeat (4) @(negedge clk);
      rd_chk("R11 rxto", 'h144, 1);
      chk("R3 irq rxto", irq, 1);
      wr('h108, 0);
      rx_send(8'h77, 1'b1);
      rd_chk("R11 rx halted", 'h108, 0);
      rx_chk("R11 queue unchanged");
      rd(32'h300, ev);
      chk("R2 final ien", ev, 32'h2_0000);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule